// File: doc/BRIEF.md
# Programmable LFSR Test Pattern Generator

This block produces pseudo-random stimulus on chip for self-test of a datapath unit. Software or a test sequencer supplies three values: a starting state, a tap mask that selects which state bits feed back, and the number of patterns wanted. A start request while the block is idle captures all three. The block then advances a shift register once per clock and shows each new state on a valid-qualified output.

On each step the state is ANDed with the tap mask, and the XOR of the surviving bits becomes the new top bit. The rest of the register moves one place toward bit 0. Because the taps come from a run-time mask rather than fixed wiring, one instance can stand in for any external-XOR polynomial of its width. A one-cycle completion pulse follows the last pattern.

Top module: `pattern_gen_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy, done and patValid are all 0.
- R2: A start seen at a rising edge while idle, with a nonzero count, captures seed, mask and count, and busy is 1 after that edge.
- R3: The feedback bit for a step is the XOR of all bits of (current state AND captured mask).
- R4: A step moves state bit i+1 into bit i and puts the feedback bit into the top bit. The pattern output shows the state after each step, so the first pattern shown is the seed after one step.
- R5: patValid is 1 for exactly N consecutive cycles, and the first of these follows the second rising edge after the start edge. Every valid pattern is shown while busy is 1.
- R6: done is 1 for exactly one cycle, in the cycle right after the last valid pattern, with busy and patValid at 0.
- R7: A start with a count of zero raises done in the cycle after the start edge. It sets no busy and emits no pattern.
- R8: Start pulses and new seed, mask or count values given while busy are ignored, and the running sequence and its length do not change.
- R9: An all-zero seed gets no special treatment: the block emits N patterns of value zero.
- R10: With a 3-bit width, mask 3'b101 and seed 3'b011, the patterns are 101, 010, 001, 100, 110, 111, 011, and then the sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; honoured only when idle |
| seedIn | input | WIDTH | Initial register state |
| maskIn | input | WIDTH | Feedback tap mask, bit i selects state bit i |
| countIn | input | CNT_W | Number of patterns to emit |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse ending a run |
| patValid | output | 1 | pattern holds a new value this cycle |
| pattern | output | WIDTH | Current generator state |

## Verification
Busy rises one edge after the start edge. Pattern k is shown after edge k+1 counted from the start edge, and done follows one edge after the last pattern. For a zero count, done appears one edge after start. The bench drives inputs on the falling edge and samples every output on each later falling edge. A behavioural model advances its own state at the same edges, so each comparison lands in the cycle where the result is due. Start pulses injected mid-run check that the expected sequence goes on unchanged.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  typedef struct packed {
    logic loadSeed;
    logic advance;
  } pgenCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } pgenState_t;

endpackage

// File: rtl/pgen_feedback.sv
module pgen_feedback #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] stateVal,
  input  logic [WIDTH-1:0] maskVal,
  output logic             fbBit
);

  logic [WIDTH-1:0] maskedBits;
  logic [WIDTH:0]   parityChain;

  assign maskedBits     = stateVal & maskVal;
  assign parityChain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_parity
    assign parityChain[i+1] = parityChain[i] ^ maskedBits[i];
  end

  assign fbBit = parityChain[WIDTH];

endmodule

// File: rtl/pgen_datapath.sv
module pgen_datapath
  import pgen_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  pgenCtrl_t        ctrl,
  input  logic [WIDTH-1:0] seedIn,
  input  logic [WIDTH-1:0] maskIn,
  output logic [WIDTH-1:0] pattern,
  output logic             patValid
);

  logic [WIDTH-1:0] stateReg;
  logic [WIDTH-1:0] maskReg;
  logic             validReg;
  logic             fbBit;

  pgen_feedback #(.WIDTH(WIDTH)) u_feedback (
    .stateVal (stateReg),
    .maskVal  (maskReg),
    .fbBit    (fbBit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stateReg <= '0;
      maskReg  <= '0;
      validReg <= 1'b0;
    end else begin
      validReg <= ctrl.advance;
      if (ctrl.loadSeed) begin
        stateReg <= seedIn;
        maskReg  <= maskIn;
      end else if (ctrl.advance) begin
        stateReg <= {fbBit, stateReg[WIDTH-1:1]};
      end
    end
  end

  assign pattern  = stateReg;
  assign patValid = validReg;

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadSeed |=> stateReg == $past(seedIn)); // R2
  AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
    ctrl.advance |=> stateReg[WIDTH-2:0] == $past(stateReg[WIDTH-1:1])); // R4
  AST_FEEDBACK_PARITY: assert property (@(posedge clk) disable iff (rst)
    ctrl.advance |=> stateReg[WIDTH-1] == ^($past(stateReg) & $past(maskReg))); // R3
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    ctrl.advance |=> maskReg == $past(maskReg)); // R8

endmodule

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startIn,
  input  logic [CNT_W-1:0] countIn,
  output pgenCtrl_t        ctrl,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  pgenState_t       state;
  logic [CNT_W-1:0] cntLeft;
  logic             doneReg;
  logic             acceptRun;
  logic             acceptEmpty;

  always_comb begin
    acceptRun     = (state == ST_IDLE) && startIn && (countIn != '0);
    acceptEmpty   = (state == ST_IDLE) && startIn && (countIn == '0);
    ctrl.loadSeed = acceptRun;
    ctrl.advance  = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cntLeft <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= acceptEmpty || (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (acceptRun) begin
            cntLeft <= countIn;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          cntLeft <= cntLeft - CNT_ONE;
          if (cntLeft == CNT_ONE) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;

  AST_RUN_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && cntLeft != CNT_ONE) |=> (state == ST_RUN) && (cntLeft == $past(cntLeft) - CNT_ONE)); // R5
  AST_RUN_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && startIn) |=> state != ST_IDLE || $past(state) == ST_FIN); // R8
  AST_EMPTY_RUN_DONE: assert property (@(posedge clk) disable iff (rst)
    acceptEmpty |=> done && !busy); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6
  AST_FIN_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |=> done && (state == ST_IDLE)); // R6

endmodule

// File: rtl/pattern_gen_top.sv
module pattern_gen_top
  import pgen_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] seedIn,
  input  logic [WIDTH-1:0] maskIn,
  input  logic [CNT_W-1:0] countIn,
  output logic             busy,
  output logic             done,
  output logic             patValid,
  output logic [WIDTH-1:0] pattern
);

  pgenCtrl_t ctrlBus;

  pgen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .startIn (start),
    .countIn (countIn),
    .ctrl    (ctrlBus),
    .busy    (busy),
    .done    (done)
  );

  pgen_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrlBus),
    .seedIn   (seedIn),
    .maskIn   (maskIn),
    .pattern  (pattern),
    .patValid (patValid)
  );

  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    patValid |-> busy && !done); // R5
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (patValid && !ctrlBus.advance) |=> done); // R6

endmodule

// File: tb/tb_pattern_gen_top.sv
module tb_pattern_gen_top;

  localparam int W  = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  seedIn = '0;
  logic [W-1:0]  maskIn = '0;
  logic [CW-1:0] countIn = '0;
  logic          busy, done, patValid;
  logic [W-1:0]  pattern;

  logic          start3 = 1'b0;
  logic [2:0]    seed3 = '0;
  logic [2:0]    mask3 = '0;
  logic [3:0]    count3 = '0;
  logic          busy3, done3, valid3;
  logic [2:0]    pattern3;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pattern_gen_top #(.WIDTH(W), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .seedIn(seedIn), .maskIn(maskIn),
    .countIn(countIn), .busy(busy), .done(done), .patValid(patValid), .pattern(pattern)
  );

  pattern_gen_top #(.WIDTH(3), .CNT_W(4)) dut3 (
    .clk(clk), .rst(rst), .start(start3), .seedIn(seed3), .maskIn(mask3),
    .countIn(count3), .busy(busy3), .done(done3), .patValid(valid3), .pattern(pattern3)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] modelStep(input logic [W-1:0] q, input logic [W-1:0] m);
    logic fb = 1'b0;
    for (int b = 0; b < W; b++) begin
      if (m[b] && q[b]) fb = ~fb;
    end
    return {fb, q[W-1:1]};
  endfunction

  // pokeAt > 0 issues a start with other inputs before step pokeAt (R8)
  task automatic runSeq(input logic [W-1:0] seed, input logic [W-1:0] mask,
                        input int count, input int pokeAt, input string patReq);
    logic [W-1:0] q;
    @(negedge clk);
    start = 1'b1; seedIn = seed; maskIn = mask; countIn = CW'(count);
    @(negedge clk);
    start = 1'b0;
    if (count == 0) begin
      chk("R7", "done", 32'(done), 1);
      chk("R7", "busy", 32'(busy), 0);
      chk("R7", "patValid", 32'(patValid), 0);
      @(negedge clk);
      chk("R6", "done drop", 32'(done), 0);
      chk("R7", "patValid", 32'(patValid), 0);
      return;
    end
    chk("R2", "busy", 32'(busy), 1);
    chk("R5", "patValid early", 32'(patValid), 0);
    chk("R6", "done early", 32'(done), 0);
    q = seed;
    for (int k = 1; k <= count; k++) begin
      if (k == pokeAt) begin
        start = 1'b1; seedIn = ~seed; maskIn = ~mask; countIn = CW'(2);
      end
      @(negedge clk);
      start = 1'b0;
      q = modelStep(q, mask);
      chk("R5", "patValid", 32'(patValid), 1);
      chk(patReq, "pattern", 32'(pattern), 32'(q));
      chk("R6", "done mid-run", 32'(done), 0);
      if (k == pokeAt) chk("R8", "busy after poke", 32'(busy), 1);
    end
    @(negedge clk);
    chk("R6", "done", 32'(done), 1);
    chk("R6", "busy", 32'(busy), 0);
    chk("R5", "patValid after last", 32'(patValid), 0);
    @(negedge clk);
    chk("R6", "done pulse width", 32'(done), 0);
  endtask

  task automatic run3();
    logic [2:0] expSeq [9] = '{3'b101, 3'b010, 3'b001, 3'b100, 3'b110,
                               3'b111, 3'b011, 3'b101, 3'b010};
    @(negedge clk);
    start3 = 1'b1; seed3 = 3'b011; mask3 = 3'b101; count3 = 4'd9;
    @(negedge clk);
    start3 = 1'b0;
    chk("R2", "busy3", 32'(busy3), 1);
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      chk("R10", "valid3", 32'(valid3), 1);
      chk("R10", "pattern3", 32'(pattern3), 32'(expSeq[k]));
    end
    @(negedge clk);
    chk("R6", "done3", 32'(done3), 1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "done in reset", 32'(done), 0);
    chk("R1", "patValid in reset", 32'(patValid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R1", "done after reset", 32'(done), 0);
    chk("R1", "patValid after reset", 32'(patValid), 0);

    runSeq(16'hACE1, 16'h002D, 20, 0, "R4");
    runSeq(16'h0001, 16'h8001, 12, 0, "R3");
    runSeq(16'hFFFF, 16'h1234, 5, 0, "R4");
    runSeq(16'h5A5A, 16'h0B01, 1, 0, "R4");
    runSeq(16'h1357, 16'h00C3, 10, 4, "R8");
    runSeq(16'h1357, 16'h00C3, 0, 0, "R7");
    runSeq(16'h0000, 16'hB400, 6, 0, "R9");
    runSeq(16'hBEEF, 16'hB400, 300, 0, "R3");
    run3();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule